// File: doc/BRIEF.md
# I2C Controller Test-Mode Line Multiplexer

This block sits between the serial controller core and the pad cells of the serial clock, serial data and SCCB-enable lines. In normal use it passes the core's three line drives straight to the pads. A test-enable bit and a two-bit test selector switch it into one of two test paths. The first puts a free-running clock on the serial clock line. Its low and high times come from the same period counts the core uses as a master. The second is a loop-back path. Each byte the core hands over for transmission in master-transmit mode comes back as a received byte, and the three lines are set directly by software control bits.

All line signals are open-drain. A 0 pulls the line low and a 1 releases it. Loop-back is refused when the controller's operating mode selects SCCB (code 10) or the unused code 11. In that case the lines stay in functional behaviour and a sticky flag records the illegal configuration. A three-bit status word returns the actual pad levels, sampled every cycle, so software can see what the lines are doing in any mode. The loop-back strobe is a one-cycle pulse per byte. The core merges it into its normal receive strobe, so the receive interrupt and DMA requests are raised in the usual way.

Top module: `i2c_systest_mux`

## Requirements
- R1: While `test_en_i` is 0, `pad_lines_o` equals `core_lines_i` in the same cycle, whatever `test_sel_i`, `op_mode_i` and `drive_ctl_i` hold, and `lb_valid_o` stays 0.
- R2: With `test_en_i` = 1, the selector codes 00 (functional) and 01 (reserved) both behave exactly like R1: the lines follow the core and no loop-back byte appears.
- R3: With `test_en_i` = 1 and selector 10, bit 0 of `pad_lines_o` (serial clock) becomes a continuous clock. It is low from the first clock edge after the mode is entered. It stays low for `scl_low_i` cycles, then high for `scl_high_i` cycles, and repeats. A count of 0 acts as 1.
- R4: When selector 10 is left, the serial clock line switches to its new source in the same cycle. On re-entry the clock restarts with a full low phase.
- R5: In selector 10, bit 1 (serial data) and bit 2 (SCCB enable) of `pad_lines_o` equal bits 1 and 2 of `drive_ctl_i`.
- R6: In legal loop-back (selector 11 with `op_mode_i` 00 or 01), `pad_lines_o` equals `drive_ctl_i`: bit 0 is the serial clock, bit 1 the serial data and bit 2 the SCCB enable.
- R7: In legal loop-back with `master_tx_i` = 1, a cycle with `tx_valid_i` = 1 gives `lb_valid_o` = 1 and `lb_data_o` = that cycle's `tx_data_i` one cycle later. With `master_tx_i` = 0 no loop-back byte appears.
- R8: Selector 11 with `op_mode_i` 10 or 11 gives functional line behaviour and no loop-back byte. It sets `illegal_cfg_o` one cycle later, and the flag stays 1 until reset.
- R9: `status_o` equals `pad_lines_i` as it was one cycle earlier, in every mode, with the same bit order as the lines.
- R10: Synchronous reset gives `lb_valid_o` = 0, `illegal_cfg_o` = 0 and `status_o` = 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en_i | input | 1 | System-test enable |
| test_sel_i | input | 2 | Test selector: 00 functional, 01 reserved, 10 clock, 11 loop-back |
| op_mode_i | input | 2 | Operating mode: 00 fast/standard, 01 high-speed, 10 SCCB, 11 unused |
| master_tx_i | input | 1 | Core is in master-transmit mode |
| scl_low_i | input | CNT_W | Low-phase length of the test clock, in cycles |
| scl_high_i | input | CNT_W | High-phase length of the test clock, in cycles |
| drive_ctl_i | input | 3 | Software line values {sccbe, sda, scl} |
| core_lines_i | input | 3 | Core line drives {sccbe, sda, scl} |
| tx_data_i | input | DATA_W | Byte written for transmission |
| tx_valid_i | input | 1 | Transmit byte strobe |
| pad_lines_i | input | 3 | Sampled pad levels {sccbe, sda, scl} |
| pad_lines_o | output | 3 | Open-drain pad drives {sccbe, sda, scl} |
| lb_data_o | output | DATA_W | Loop-back receive byte |
| lb_valid_o | output | 1 | Loop-back receive strobe |
| status_o | output | 3 | Registered pad levels |
| illegal_cfg_o | output | 1 | Sticky flag for loop-back requested under SCCB or the unused mode |

## Verification
Assertions check several behaviours on every cycle. These are the pass-through while test is off, the one-cycle loop-back echo and its absence when the loop-back conditions are not met, the stickiness of the illegal-configuration flag, the one-cycle status delay, and the clock sitting high while idle and starting low on entry. Only the bench scenarios can show the exact low and high phase lengths across a sweep of period counts, including the zero-count case. The same holds for the immediate hand-over when the clock mode is left and the full low phase on re-entry. The bench also sweeps every selector, operating-mode and drive-bit combination against the expected line values, and sends all byte values through the loop-back.

// File: rtl/i2c_systest_pkg.sv
package i2c_systest_pkg;

    localparam int LINE_W    = 3;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;
    localparam int LINE_SCCB = 2;

    typedef struct packed {
        logic sccbe;
        logic sda;
        logic scl;
    } lines_t;

    typedef enum logic [1:0] {
        PATH_FUNC = 2'd0,
        PATH_SCLK = 2'd1,
        PATH_LOOP = 2'd2
    } path_e;

    localparam logic [1:0] SEL_FUNC = 2'b00;
    localparam logic [1:0] SEL_RSVD = 2'b01;
    localparam logic [1:0] SEL_SCLK = 2'b10;
    localparam logic [1:0] SEL_LOOP = 2'b11;

    // SCCB (10) and the unused code (11) both have bit 1 set
    function automatic logic loop_refused(logic en, logic [1:0] sel, logic [1:0] op);
        return en && (sel == SEL_LOOP) && op[1];
    endfunction

    function automatic path_e pick_path(logic en, logic [1:0] sel, logic [1:0] op);
        path_e p;
        p = PATH_FUNC;
        if (en) begin
            case (sel)
                SEL_SCLK: p = PATH_SCLK;
                SEL_LOOP: p = op[1] ? PATH_FUNC : PATH_LOOP;
                default:  p = PATH_FUNC;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/i2c_st_clkgen.sv
module i2c_st_clkgen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    output logic             scl_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] cur_len;
    logic             run_q;
    logic             scl_q;

    always_comb begin
        low_len  = (low_i  == '0) ? ONE : low_i;
        high_len = (high_i == '0) ? ONE : high_i;
        cur_len  = scl_q ? high_len : low_len;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            scl_q <= 1'b1;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            scl_q <= 1'b0;
            cnt_q <= '0;
        end else if (cnt_q == cur_len - ONE) begin
            scl_q <= ~scl_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign scl_o = scl_q;

    AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> scl_o) else $error("idle clock not released"); // R4
    AST_CLK_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (!en_i ##1 en_i) |=> !scl_o) else $error("clock did not start low"); // R3
endmodule

// File: rtl/i2c_st_loopback.sv
module i2c_st_loopback #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en_i,
    input  logic              refused_i,
    input  logic              master_tx_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic [DATA_W-1:0] lb_data_o,
    output logic              lb_valid_o,
    output logic              illegal_o
);
    logic              take;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              bad_q;

    assign take = loop_en_i && master_tx_i && tx_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) data_q <= tx_data_i;
            if (refused_i) bad_q <= 1'b1;
        end
    end

    assign lb_data_o  = data_q;
    assign lb_valid_o = valid_q;
    assign illegal_o  = bad_q;

    AST_LB_ECHO: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && master_tx_i && loop_en_i) |=> (lb_valid_o && lb_data_o == $past(tx_data_i)))
        else $error("loop-back byte lost"); // R7
    AST_LB_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid_i && master_tx_i && loop_en_i) |=> !lb_valid_o)
        else $error("spurious loop-back byte"); // R7
    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> illegal_o) else $error("illegal flag cleared"); // R8
    AST_ILLEGAL_SET: assert property (@(posedge clk) disable iff (rst)
        refused_i |=> illegal_o) else $error("illegal flag not set"); // R8
endmodule

// File: rtl/i2c_systest_mux.sv
module i2c_systest_mux
    import i2c_systest_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en_i,
    input  logic [1:0]        test_sel_i,
    input  logic [1:0]        op_mode_i,
    input  logic              master_tx_i,
    input  logic [CNT_W-1:0]  scl_low_i,
    input  logic [CNT_W-1:0]  scl_high_i,
    input  logic [2:0]        drive_ctl_i,
    input  logic [2:0]        core_lines_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic [2:0]        pad_lines_i,
    output logic [2:0]        pad_lines_o,
    output logic [DATA_W-1:0] lb_data_o,
    output logic              lb_valid_o,
    output logic [2:0]        status_o,
    output logic              illegal_cfg_o
);
    path_e  path;
    logic   refused;
    logic   gen_scl;
    lines_t core_l, drv_l, out_l;
    lines_t stat_q;

    always_comb begin
        path    = pick_path(test_en_i, test_sel_i, op_mode_i);
        refused = loop_refused(test_en_i, test_sel_i, op_mode_i);
        core_l  = lines_t'(core_lines_i);
        drv_l   = lines_t'(drive_ctl_i);
    end

    i2c_st_clkgen #(.CNT_W(CNT_W)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .en_i   (path == PATH_SCLK),
        .low_i  (scl_low_i),
        .high_i (scl_high_i),
        .scl_o  (gen_scl)
    );

    i2c_st_loopback #(.DATA_W(DATA_W)) u_loop (
        .clk         (clk),
        .rst         (rst),
        .loop_en_i   (path == PATH_LOOP),
        .refused_i   (refused),
        .master_tx_i (master_tx_i),
        .tx_data_i   (tx_data_i),
        .tx_valid_i  (tx_valid_i),
        .lb_data_o   (lb_data_o),
        .lb_valid_o  (lb_valid_o),
        .illegal_o   (illegal_cfg_o)
    );

    always_comb begin
        unique case (path)
            PATH_SCLK: begin
                out_l     = drv_l;
                out_l.scl = gen_scl;
            end
            PATH_LOOP: out_l = drv_l;
            default:   out_l = core_l;
        endcase
    end

    assign pad_lines_o = out_l;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '1;
        else     stat_q <= lines_t'(pad_lines_i);
    end

    assign status_o = stat_q;

    AST_TEST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
        !test_en_i |-> (pad_lines_o == core_lines_i)) else $error("lines not passed"); // R1
    AST_STATUS_DELAY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_o == $past(pad_lines_i))) else $error("status lag wrong"); // R9
endmodule

// File: tb/i2c_systest_mux_tb_top.sv
module i2c_systest_mux_tb_top;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              test_en_i;
    logic [1:0]        test_sel_i;
    logic [1:0]        op_mode_i;
    logic              master_tx_i;
    logic [CNT_W-1:0]  scl_low_i;
    logic [CNT_W-1:0]  scl_high_i;
    logic [2:0]        drive_ctl_i;
    logic [2:0]        core_lines_i;
    logic [DATA_W-1:0] tx_data_i;
    logic              tx_valid_i;
    logic [2:0]        pad_lines_i;
    logic [2:0]        pad_lines_o;
    logic [DATA_W-1:0] lb_data_o;
    logic              lb_valid_o;
    logic [2:0]        status_o;
    logic              illegal_cfg_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    i2c_systest_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst = 1; test_en_i = 0; test_sel_i = 0; op_mode_i = 0; master_tx_i = 0;
        scl_low_i = 2; scl_high_i = 2; drive_ctl_i = 0; core_lines_i = 3'b111;
        tx_data_i = 0; tx_valid_i = 0; pad_lines_i = 3'b010;
        repeat (3) tick();
        // R10 reset state
        chk(lb_valid_o == 0, "R10", lb_valid_o, 0);
        chk(illegal_cfg_o == 0, "R10", illegal_cfg_o, 0);
        chk(status_o == 3'b111, "R10", status_o, 7);
        rst = 0;

        // R1 test off: every selector, op mode, drive and core pattern
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int d = 0; d < 8; d++)
                    for (int c = 0; c < 8; c++) begin
                        test_en_i = 0; test_sel_i = s[1:0]; op_mode_i = o[1:0];
                        drive_ctl_i = d[2:0]; core_lines_i = c[2:0];
                        master_tx_i = 1; tx_valid_i = 1; tx_data_i = 8'h5A;
                        #1;
                        chk(pad_lines_o == c[2:0], "R1", pad_lines_o, c);
                        tick();
                        chk(lb_valid_o == 0, "R1", lb_valid_o, 0);
                    end

        // R2 functional and reserved selectors with test on
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 8; d++)
                for (int c = 0; c < 8; c++) begin
                    test_en_i = 1; test_sel_i = s[1:0]; op_mode_i = 0;
                    drive_ctl_i = d[2:0]; core_lines_i = c[2:0];
                    #1;
                    chk(pad_lines_o == c[2:0], "R2", pad_lines_o, c);
                    tick();
                    chk(lb_valid_o == 0, "R2", lb_valid_o, 0);
                end
        tx_valid_i = 0;

        // R6 legal loop-back: lines follow drive bits
        for (int o = 0; o < 2; o++)
            for (int d = 0; d < 8; d++) begin
                test_en_i = 1; test_sel_i = 2'b11; op_mode_i = o[1:0];
                drive_ctl_i = d[2:0]; core_lines_i = ~d[2:0];
                #1;
                chk(pad_lines_o == d[2:0], "R6", pad_lines_o, d);
            end

        // R3 clock sweep, counts 0..4 (0 behaves as 1)
        for (int lo = 0; lo < 5; lo++)
            for (int hi = 0; hi < 5; hi++) begin
                int el, eh, per;
                test_en_i = 1; test_sel_i = 2'b00; tick();
                scl_low_i = lo[CNT_W-1:0]; scl_high_i = hi[CNT_W-1:0];
                el = (lo == 0) ? 1 : lo;
                eh = (hi == 0) ? 1 : hi;
                per = el + eh;
                test_sel_i = 2'b10; drive_ctl_i = 3'b101; core_lines_i = 3'b000;
                #1;
                chk(pad_lines_o[0] == 1'b1, "R3", pad_lines_o[0], 1);
                for (int k = 0; k < 3 * per; k++) begin
                    int e;
                    tick();
                    e = ((k % per) < el) ? 0 : 1;
                    chk(pad_lines_o[0] == e[0], "R3", pad_lines_o[0], e);
                    // R5 data and enable lines follow drive bits
                    chk(pad_lines_o[2:1] == 2'b10, "R5", pad_lines_o[2:1], 2);
                end
            end

        // R4 leave during low phase, line moves immediately; re-entry restarts low
        scl_low_i = 3; scl_high_i = 3;
        test_sel_i = 2'b00; tick();
        test_sel_i = 2'b10; tick();
        chk(pad_lines_o[0] == 0, "R4", pad_lines_o[0], 0);
        test_sel_i = 2'b11; op_mode_i = 0; drive_ctl_i = 3'b001;
        #1;
        chk(pad_lines_o[0] == 1, "R4", pad_lines_o[0], 1);
        tick(); tick();
        test_sel_i = 2'b10;
        for (int k = 0; k < 6; k++) begin
            int e;
            tick();
            e = (k < 3) ? 0 : 1;
            chk(pad_lines_o[0] == e[0], "R4", pad_lines_o[0], e);
        end

        // R7 loop-back of every byte value
        test_sel_i = 2'b11; op_mode_i = 2'b01; master_tx_i = 1;
        for (int b = 0; b < 256; b++) begin
            tx_data_i = b[7:0]; tx_valid_i = 1;
            tick();
            chk(lb_valid_o == 1, "R7", lb_valid_o, 1);
            chk(lb_data_o == b[7:0], "R7", lb_data_o, b);
            tx_valid_i = 0;
            tick();
            chk(lb_valid_o == 0, "R7", lb_valid_o, 0);
        end
        master_tx_i = 0; tx_valid_i = 1; tx_data_i = 8'h33;
        tick();
        chk(lb_valid_o == 0, "R7", lb_valid_o, 0);
        tx_valid_i = 0;
        chk(illegal_cfg_o == 0, "R8", illegal_cfg_o, 0);

        // R8 loop-back refused under SCCB and unused mode
        for (int o = 2; o < 4; o++) begin
            test_sel_i = 2'b11; op_mode_i = o[1:0]; master_tx_i = 1;
            drive_ctl_i = 3'b000; core_lines_i = 3'b110; tx_valid_i = 1;
            #1;
            chk(pad_lines_o == 3'b110, "R8", pad_lines_o, 6);
            tick();
            chk(lb_valid_o == 0, "R8", lb_valid_o, 0);
            chk(illegal_cfg_o == 1, "R8", illegal_cfg_o, 1);
            tx_valid_i = 0;
            test_sel_i = 2'b00;
            tick(); tick();
            chk(illegal_cfg_o == 1, "R8", illegal_cfg_o, 1);
            rst = 1; tick(); rst = 0;
            chk(illegal_cfg_o == 0, "R8", illegal_cfg_o, 0);
        end

        // R9 status follows pads one cycle later in every path
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 8; p++) begin
                test_en_i = 1; test_sel_i = s[1:0]; op_mode_i = 0;
                pad_lines_i = p[2:0];
                tick();
                chk(status_o == p[2:0], "R9", status_o, p);
            end

        finish_run();
    end
endmodule